// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the controller of a three-bus datapath. Every clock cycle it presents one control word. The word says which sources drive bus A and bus B, which single source drives bus C (the ALU result or memory read data), which function the ALU performs, which register-file ports are addressed, and which destinations capture bus C at the next clock edge. Every instruction starts with the same two-cycle fetch: the instruction register is loaded from memory at the PC, and then the PC is incremented through the ALU. The controller then decodes the opcode held in the instruction register and steps through that opcode's own execute steps.

The supported operations are add, subtract, set-less-than, load word, branch-if-zero and jump-and-link. Each operation is written as an explicit list of single-cycle register transfers, and each transfer is exactly one control word. The controller reads only two inputs: the instruction register contents and the zero flag from the ALU. An opcode it does not recognise sends it to a halt state. It leaves that state only through reset.

The bus sources are as follows. Bus A can be driven by register-file port a, the immediate field, or the constant one. Bus B can be driven by register-file port b, the PC, or the temporary register. The memory address is taken from bus B.

Top module: `msq_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the outputs show fetch step one: `b_pc_oe`, `mem_rd` and `ir_we` are high, every other enable is low, `halted` is low, all selects are 0 and `alu_func` is 0.
- R2: Fetch step two follows fetch step one in the very next cycle. It drives `a_one_oe` and `b_pc_oe`, sets `alu_func`=0 (add), and raises `c_alu_oe` and `pc_we`.
- R3: The instruction word is split into fields: opcode in bits 31:28, rd in 27:24, rs in 23:20, rt in 19:16 and immediate in 15:0. Opcodes 0 (add), 1 (subtract) and 2 (set-less-than) take one execute step. That step sets `a_reg_oe` with `sel_a`=rs, `b_reg_oe` with `sel_b`=rt, `alu_func` equal to the opcode value, `c_alu_oe`, and `reg_we` with `sel_c`=rd.
- R4: Opcode 3 (load word) takes two execute steps. The first step sets `b_reg_oe` with `sel_b`=rs, `a_imm_oe`, add, `c_alu_oe` and `temp_we`. The second step sets `b_temp_oe`, `mem_rd`, and `reg_we` with `sel_c`=rd.
- R5: Opcode 4 (branch-if-zero) first runs a test step: `a_reg_oe` with `sel_a`=rs and `alu_func`=3 (pass A), with no write enable. If `alu_zero` is high in that cycle, one more step follows: `b_pc_oe`, `a_imm_oe`, add, `c_alu_oe` and `pc_we`. If `alu_zero` is low, fetch follows directly.
- R6: Opcode 5 (jump-and-link) first writes the already-incremented PC to register 15. This step sets `b_pc_oe`, `alu_func`=4 (pass B), `c_alu_oe`, and `reg_we` with `sel_c`=15. The next step loads the PC with the immediate: `a_imm_oe`, pass A, `c_alu_oe` and `pc_we`.
- R7: The cycle after the final execute step of any instruction is fetch step one.
- R8: Opcodes 6 to 15 lead, after fetch, to a halt state. In that state `halted` is high, every enable and select is zero, and `alu_func` is 0. The state holds whatever `ir_word` and `alu_zero` do, until reset.
- R9: In every cycle at most one source drives each of bus A, bus B and bus C. A write enable (`reg_we`, `pc_we`, `ir_we`, `temp_we`) is raised only when a bus C source is active. Any select that is not in use is 0. The ALU function is 0 when no other function is required.
- R10: `alu_zero` has no effect outside the branch test step. For example, an arithmetic or load instruction takes the same steps whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one control step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_word | input | 32 | Current instruction register contents |
| alu_zero | input | 1 | ALU result-is-zero flag |
| a_reg_oe | output | 1 | Register-file port a drives bus A |
| a_imm_oe | output | 1 | Immediate field drives bus A |
| a_one_oe | output | 1 | Constant one drives bus A |
| b_reg_oe | output | 1 | Register-file port b drives bus B |
| b_pc_oe | output | 1 | PC drives bus B |
| b_temp_oe | output | 1 | Temporary register drives bus B |
| c_alu_oe | output | 1 | ALU result drives bus C |
| mem_rd | output | 1 | Memory read at the bus B address; data drives bus C |
| sel_a | output | 4 | Register-file port a index |
| sel_b | output | 4 | Register-file port b index |
| sel_c | output | 4 | Register-file write index |
| alu_func | output | 3 | 0 add, 1 sub, 2 slt, 3 pass A, 4 pass B |
| reg_we | output | 1 | Register file captures bus C |
| pc_we | output | 1 | PC captures bus C |
| ir_we | output | 1 | Instruction register captures bus C |
| temp_we | output | 1 | Temporary register captures bus C |
| halted | output | 1 | Controller is in the halt state |

## Verification
The assertions assume that `ir_word` changes only at the clock edge where `ir_we` is high, because this is how a real instruction register behaves. The branch-guard property also assumes that `alu_zero` is valid in the test step of a branch. The bench models this. It loads its instruction variable only in the fetch-one cycle, and it sets the zero flag before the execute steps begin. The one exception is the halt test. There the instruction input is deliberately changed while the controller is halted, and that state does not decode the instruction.

// File: rtl/msq_pkg.sv
package msq_pkg;

    typedef enum logic [3:0] {
        ST_FETCH_IR  = 4'd0,
        ST_FETCH_INC = 4'd1,
        ST_ALU       = 4'd2,
        ST_LW_ADDR   = 4'd3,
        ST_LW_MEM    = 4'd4,
        ST_BZ_TEST   = 4'd5,
        ST_BZ_TAKE   = 4'd6,
        ST_JAL_LINK  = 4'd7,
        ST_JAL_JUMP  = 4'd8,
        ST_HALT      = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        FN_ADD    = 3'd0,
        FN_SUB    = 3'd1,
        FN_SLT    = 3'd2,
        FN_PASS_A = 3'd3,
        FN_PASS_B = 3'd4
    } alu_fn_e;

    // Result of decoding the opcode: the first execute step and the ALU op.
    typedef struct packed {
        step_e   entry;
        alu_fn_e fn;
    } dec_t;

    // Enables of one control word; selects are carried separately.
    typedef struct packed {
        logic a_reg;
        logic a_imm;
        logic a_one;
        logic b_reg;
        logic b_pc;
        logic b_temp;
        logic c_alu;
        logic mem_rd;
        logic reg_we;
        logic pc_we;
        logic ir_we;
        logic temp_we;
        logic halted;
    } en_t;

    typedef struct packed {
        step_e step;
    } seq_state_t;

endpackage

// File: rtl/msq_op_decode.sv
module msq_op_decode
    import msq_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    localparam logic [OPC_W-1:0] OP_ADD = OPC_W'(0);
    localparam logic [OPC_W-1:0] OP_SUB = OPC_W'(1);
    localparam logic [OPC_W-1:0] OP_SLT = OPC_W'(2);
    localparam logic [OPC_W-1:0] OP_LW  = OPC_W'(3);
    localparam logic [OPC_W-1:0] OP_BZ  = OPC_W'(4);
    localparam logic [OPC_W-1:0] OP_JAL = OPC_W'(5);

    always_comb begin
        dec.entry = ST_HALT;
        dec.fn    = FN_ADD;
        case (opcode)
            OP_ADD: begin dec.entry = ST_ALU; dec.fn = FN_ADD; end
            OP_SUB: begin dec.entry = ST_ALU; dec.fn = FN_SUB; end
            OP_SLT: begin dec.entry = ST_ALU; dec.fn = FN_SLT; end
            OP_LW:  dec.entry = ST_LW_ADDR;
            OP_BZ:  dec.entry = ST_BZ_TEST;
            OP_JAL: dec.entry = ST_JAL_LINK;
            default: dec.entry = ST_HALT;
        endcase
    end

endmodule

// File: rtl/msq_step_seq.sv
module msq_step_seq
    import msq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_e entry,
    input  logic  alu_zero,
    output step_e step
);

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q.step)
            ST_FETCH_IR:  state_d.step = ST_FETCH_INC;
            ST_FETCH_INC: state_d.step = entry;
            ST_ALU:       state_d.step = ST_FETCH_IR;
            ST_LW_ADDR:   state_d.step = ST_LW_MEM;
            ST_LW_MEM:    state_d.step = ST_FETCH_IR;
            ST_BZ_TEST:   state_d.step = alu_zero ? ST_BZ_TAKE : ST_FETCH_IR;
            ST_BZ_TAKE:   state_d.step = ST_FETCH_IR;
            ST_JAL_LINK:  state_d.step = ST_JAL_JUMP;
            ST_JAL_JUMP:  state_d.step = ST_FETCH_IR;
            ST_HALT:      state_d.step = ST_HALT;
            default:      state_d.step = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.step <= ST_FETCH_IR;
        end else begin
            state_q <= state_d;
        end
    end

    assign step = state_q.step;

    // Halt is left only through reset (R8).
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.step == ST_HALT) |=> (state_q.step == ST_HALT));

    // The branch adds its offset only after a test step that saw zero (R5).
    p_branch_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.step == ST_BZ_TAKE) |-> ($past(state_q.step) == ST_BZ_TEST && $past(alu_zero)));

    // Every step that ends an instruction hands over to fetch (R7).
    p_return_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.step inside {ST_ALU, ST_LW_MEM, ST_BZ_TAKE, ST_JAL_JUMP}) |=> (state_q.step == ST_FETCH_IR));

endmodule

// File: rtl/msq_ctrl_encode.sv
module msq_ctrl_encode
    import msq_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int LINK_REG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  alu_fn_e          dec_fn,
    input  logic [SEL_W-1:0] rd,
    input  logic [SEL_W-1:0] rs,
    input  logic [SEL_W-1:0] rt,
    output en_t              en,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic [SEL_W-1:0] sel_c,
    output alu_fn_e          fn
);

    localparam logic [SEL_W-1:0] LINK_IDX = SEL_W'(LINK_REG);

    always_comb begin
        en    = '0;
        sel_a = '0;
        sel_b = '0;
        sel_c = '0;
        fn    = FN_ADD;
        case (step)
            ST_FETCH_IR: begin
                en.b_pc = 1'b1; en.mem_rd = 1'b1; en.ir_we = 1'b1;
            end
            ST_FETCH_INC: begin
                en.a_one = 1'b1; en.b_pc = 1'b1; en.c_alu = 1'b1; en.pc_we = 1'b1;
                fn = FN_ADD;
            end
            ST_ALU: begin
                en.a_reg = 1'b1; sel_a = rs;
                en.b_reg = 1'b1; sel_b = rt;
                fn = dec_fn;
                en.c_alu = 1'b1; en.reg_we = 1'b1; sel_c = rd;
            end
            ST_LW_ADDR: begin
                en.b_reg = 1'b1; sel_b = rs;
                en.a_imm = 1'b1; fn = FN_ADD;
                en.c_alu = 1'b1; en.temp_we = 1'b1;
            end
            ST_LW_MEM: begin
                en.b_temp = 1'b1; en.mem_rd = 1'b1;
                en.reg_we = 1'b1; sel_c = rd;
            end
            ST_BZ_TEST: begin
                en.a_reg = 1'b1; sel_a = rs; fn = FN_PASS_A;
            end
            ST_BZ_TAKE: begin
                en.b_pc = 1'b1; en.a_imm = 1'b1; fn = FN_ADD;
                en.c_alu = 1'b1; en.pc_we = 1'b1;
            end
            ST_JAL_LINK: begin
                en.b_pc = 1'b1; fn = FN_PASS_B;
                en.c_alu = 1'b1; en.reg_we = 1'b1; sel_c = LINK_IDX;
            end
            ST_JAL_JUMP: begin
                en.a_imm = 1'b1; fn = FN_PASS_A;
                en.c_alu = 1'b1; en.pc_we = 1'b1;
            end
            ST_HALT: en.halted = 1'b1;
            default: en.halted = 1'b1;
        endcase
    end

    // One driver per bus (R9).
    p_bus_a_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en.a_reg, en.a_imm, en.a_one}));
    p_bus_b_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en.b_reg, en.b_pc, en.b_temp}));
    p_bus_c_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en.c_alu, en.mem_rd}));
    // A destination only captures bus C when something drives it (R9).
    p_write_has_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en.reg_we || en.pc_we || en.ir_we || en.temp_we) |-> (en.c_alu || en.mem_rd));
    // Halt is quiet on every bus (R8).
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en.halted |-> ($countones(en) == 1 && sel_c == '0));

endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
    import msq_pkg::*;
#(
    parameter int IR_W     = 32,
    parameter int OPC_W    = 4,
    parameter int SEL_W    = 4,
    parameter int LINK_REG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IR_W-1:0]  ir_word,
    input  logic             alu_zero,
    output logic             a_reg_oe,
    output logic             a_imm_oe,
    output logic             a_one_oe,
    output logic             b_reg_oe,
    output logic             b_pc_oe,
    output logic             b_temp_oe,
    output logic             c_alu_oe,
    output logic             mem_rd,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic [SEL_W-1:0] sel_c,
    output logic [2:0]       alu_func,
    output logic             reg_we,
    output logic             pc_we,
    output logic             ir_we,
    output logic             temp_we,
    output logic             halted
);

    // Field positions, packed from the top of the word downward.
    localparam int OPC_LSB = IR_W - OPC_W;
    localparam int RD_LSB  = OPC_LSB - SEL_W;
    localparam int RS_LSB  = RD_LSB - SEL_W;
    localparam int RT_LSB  = RS_LSB - SEL_W;

    logic [OPC_W-1:0] opcode;
    logic [SEL_W-1:0] rd, rs, rt;
    dec_t             dec;
    step_e            step;
    en_t              en;
    alu_fn_e          fn;

    assign opcode = ir_word[OPC_LSB +: OPC_W];
    assign rd     = ir_word[RD_LSB +: SEL_W];
    assign rs     = ir_word[RS_LSB +: SEL_W];
    assign rt     = ir_word[RT_LSB +: SEL_W];

    msq_op_decode #(.OPC_W(OPC_W)) u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    msq_step_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .entry    (dec.entry),
        .alu_zero (alu_zero),
        .step     (step)
    );

    msq_ctrl_encode #(.SEL_W(SEL_W), .LINK_REG(LINK_REG)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .dec_fn (dec.fn),
        .rd     (rd),
        .rs     (rs),
        .rt     (rt),
        .en     (en),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .sel_c  (sel_c),
        .fn     (fn)
    );

    assign a_reg_oe  = en.a_reg;
    assign a_imm_oe  = en.a_imm;
    assign a_one_oe  = en.a_one;
    assign b_reg_oe  = en.b_reg;
    assign b_pc_oe   = en.b_pc;
    assign b_temp_oe = en.b_temp;
    assign c_alu_oe  = en.c_alu;
    assign mem_rd    = en.mem_rd;
    assign alu_func  = fn;
    assign reg_we    = en.reg_we;
    assign pc_we     = en.pc_we;
    assign ir_we     = en.ir_we;
    assign temp_we   = en.temp_we;
    assign halted    = en.halted;

    // Loading the instruction register is always followed by the PC increment (R2).
    p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> (pc_we && a_one_oe && b_pc_oe));

endmodule

// File: tb/msq_sequencer_tb.sv
module msq_sequencer_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ir_word;
    logic        alu_zero;
    logic a_reg_oe, a_imm_oe, a_one_oe, b_reg_oe, b_pc_oe, b_temp_oe, c_alu_oe, mem_rd;
    logic [3:0] sel_a, sel_b, sel_c;
    logic [2:0] alu_func;
    logic reg_we, pc_we, ir_we, temp_we, halted;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    msq_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .ir_word(ir_word), .alu_zero(alu_zero),
        .a_reg_oe(a_reg_oe), .a_imm_oe(a_imm_oe), .a_one_oe(a_one_oe),
        .b_reg_oe(b_reg_oe), .b_pc_oe(b_pc_oe), .b_temp_oe(b_temp_oe),
        .c_alu_oe(c_alu_oe), .mem_rd(mem_rd),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .alu_func(alu_func),
        .reg_we(reg_we), .pc_we(pc_we), .ir_we(ir_we), .temp_we(temp_we),
        .halted(halted)
    );

    logic [27:0] cw;
    assign cw = {a_reg_oe, a_imm_oe, a_one_oe, b_reg_oe, b_pc_oe, b_temp_oe, c_alu_oe, mem_rd,
                 sel_a, sel_b, sel_c, alu_func, reg_we, pc_we, ir_we, temp_we, halted};

    function automatic logic [27:0] mk(
        input logic ar, ai, a1, br, bp, bt, ca, mr,
        input logic [3:0] sa, sb, sc, input logic [2:0] fn,
        input logic rw, pw, iw, tw, h);
        return {ar, ai, a1, br, bp, bt, ca, mr, sa, sb, sc, fn, rw, pw, iw, tw, h};
    endfunction

    localparam logic [27:0] W_FETCH1 = {8'b0000_1001, 12'h000, 3'd0, 5'b00100};
    localparam logic [27:0] W_FETCH2 = {8'b0010_1010, 12'h000, 3'd0, 5'b01000};
    localparam logic [27:0] W_HALT   = {8'b0000_0000, 12'h000, 3'd0, 5'b00001};

    // Expected execute step s of an instruction (R3..R6).
    function automatic logic [27:0] exp_exec(input logic [31:0] ins, input int s);
        logic [3:0] op, rd, rs, rt;
        op = ins[31:28]; rd = ins[27:24]; rs = ins[23:20]; rt = ins[19:16];
        case (op)
            4'd0, 4'd1, 4'd2: return mk(1,0,0,1,0,0,1,0, rs, rt, rd, op[2:0], 1,0,0,0,0);
            4'd3: return (s == 0) ? mk(0,1,0,1,0,0,1,0, 4'd0, rs, 4'd0, 3'd0, 0,0,0,1,0)
                                  : mk(0,0,0,0,0,1,0,1, 4'd0, 4'd0, rd, 3'd0, 1,0,0,0,0);
            4'd4: return (s == 0) ? mk(1,0,0,0,0,0,0,0, rs, 4'd0, 4'd0, 3'd3, 0,0,0,0,0)
                                  : mk(0,1,0,0,1,0,1,0, 4'd0, 4'd0, 4'd0, 3'd0, 0,1,0,0,0);
            4'd5: return (s == 0) ? mk(0,0,0,0,1,0,1,0, 4'd0, 4'd0, 4'd15, 3'd4, 1,0,0,0,0)
                                  : mk(0,1,0,0,0,0,1,0, 4'd0, 4'd0, 4'd0, 3'd3, 0,1,0,0,0);
            default: return W_HALT;
        endcase
    endfunction

    function automatic int n_steps(input logic [3:0] op, input logic z);
        case (op)
            4'd0, 4'd1, 4'd2: return 1;
            4'd3, 4'd5:       return 2;
            4'd4:             return z ? 2 : 1;
            default:          return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2: return "R3";
            4'd3:             return "R4";
            4'd4:             return "R5";
            4'd5:             return "R6";
            default:          return "R8";
        endcase
    endfunction

    task automatic chk(input logic [27:0] exp, input string req);
        n_chk++;
        if (cw !== exp) begin
            n_fail++;
            $display("FAIL %s: control word got %h expected %h", req, cw, exp);
        end
    endtask

    // Runs fetch plus execute; the bench sits just after a falling edge in fetch step one.
    task automatic run_instr(input logic [31:0] ins, input logic z, input string after_req);
        chk(W_FETCH1, "R7");
        ir_word = ins;
        @(negedge clk);
        chk(W_FETCH2, "R2");
        @(negedge clk);
        alu_zero = z;
        for (int s = 0; s < n_steps(ins[31:28], z); s++) begin
            chk(exp_exec(ins, s), req_of(ins[31:28]));
            @(negedge clk);
        end
        chk(W_FETCH1, after_req);
    endtask

    // {instruction, alu_zero}
    localparam logic [32:0] VEC [8] = '{
        {32'h0123_0000, 1'b1},
        {32'h1456_0000, 1'b0},
        {32'h2789_0000, 1'b1},
        {32'h3AB0_0010, 1'b0},
        {32'h40C0_0004, 1'b1},
        {32'h40D0_0004, 1'b0},
        {32'h5000_0100, 1'b0},
        {32'h0F0E_0000, 1'b0}
    };

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(W_FETCH1, "R1 during reset");
        rst_n = 1'b1;
        chk(W_FETCH1, "R1 after release");
    endtask

    initial begin
        rst_n    = 1'b0;
        ir_word  = 32'h0;
        alu_zero = 1'b0;
        @(negedge clk);
        do_reset();

        for (int i = 0; i < 8; i++) begin
            run_instr(VEC[i][32:1], VEC[i][0], "R7 after final step");
        end

        // R10: zero flag high through an arithmetic and a load
        run_instr(32'h1321_0000, 1'b1, "R10 zero ignored by sub");
        run_instr(32'h3450_0002, 1'b1, "R10 zero ignored by load");

        // R8: unknown opcode 9 halts and ignores inputs
        chk(W_FETCH1, "R7");
        ir_word = 32'h9000_0000;
        @(negedge clk);
        chk(W_FETCH2, "R2");
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk(W_HALT, "R8 halt holds");
            ir_word  = 32'h0123_0000 + k;
            alu_zero = k[0];
            @(negedge clk);
        end
        chk(W_HALT, "R8 halt holds");
        do_reset();

        // R8: top opcode 15 and opcode 6 also halt
        ir_word = 32'hF000_0000;
        @(negedge clk);
        @(negedge clk);
        chk(W_HALT, "R8 opcode 15");
        do_reset();
        ir_word = 32'h6000_0000;
        @(negedge clk);
        @(negedge clk);
        chk(W_HALT, "R8 opcode 6");
        do_reset();

        // After reset from halt the sequencer runs again
        run_instr(32'h5000_0040, 1'b1, "R7 after jump-and-link");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule